// File: doc/BRIEF.md
# Timed Requirement Monitor Array

This block checks, inside a running simulation or emulation, that a design under test reacts to a trigger within a bounded time. Each monitor watches a small status code and a response bit. When the code equals the caution value, a response window opens. The window is measured in ticks of a slow time base. If the response arrives before the window closes, the requirement counts as exercised and kept. If the window runs out first, it counts as exercised and broken.

Every monitor holds two sticky flags. One records that its requirement was checked at least once. The other records that it was broken at least once. A verdict stage joins N monitors into a pass flag and a fail flag. Pass needs every monitor to be exercised and none to be broken, so a requirement that was never stimulated keeps the run from passing.

Top module: `rvm_array`

## Requirements
- R1: Monitor i reads its status code from bits [i*STW +: STW] of `status` (2-bit field by default). Only the caution code 1 opens a window. Codes 0, 2 and 3 never open one and never change any flag.
- R2: The requirement is met when the response bit is high on the edge that samples the trigger, or on any later edge before the window expires. `evaluated` then rises one cycle after that edge, and `violated` stays low.
- R3: While a window is open, each edge with `tick` high and no response counts one tick. The edge that samples the WIN_TICKS-th such tick sets `violated` and `evaluated` together, unless the response is high on that same edge, in which case it is in time.
- R4: Ticks are counted only while a window is open, and the trigger edge itself does not count. A caution code seen while a window is already open does not restart it.
- R5: `evaluated` and `violated` are sticky: once set, they stay set until reset.
- R6: A monitor that has never been triggered keeps `evaluated` low, and `test_pass` stays low while any monitor is unevaluated.
- R7: `test_pass` is high exactly when all N `evaluated` bits are high and no `violated` bit is high. It follows the flags in the same cycle in the default combinational verdict.
- R8: `test_fail` is high in the same cycle that any `violated` bit is high.
- R9: A synchronous reset clears all flags and any open window. No response or tick seen after the reset completes a window that was open before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base strobe, one clock wide per tick |
| status | input | N_MON*STW | Packed per-monitor status codes |
| resp | input | N_MON | Per-monitor expected response (alarm active) |
| evaluated | output | N_MON | Sticky: requirement checked at least once |
| violated | output | N_MON | Sticky: requirement broken at least once |
| test_pass | output | 1 | All evaluated and none violated |
| test_fail | output | 1 | Any requirement violated |

## Verification
The per-monitor flags are registered. They change one clock after the edge that samples the trigger-with-response, the late response, or the final tick. The verdict outputs change in that same cycle in the default configuration. The bench drives inputs on the falling edge and updates its requirement model immediately, so the model predicts the state after the next rising edge. It then compares every output on the following falling edge, which is exactly one register stage later. Directed checks count ticks from the trigger edge so that the WIN_TICKS-th tick, with and without a response, lands on a known edge.

// File: rtl/rvm_pkg.sv
package rvm_pkg;
   typedef enum logic {
      MS_IDLE  = 1'b0,
      MS_ARMED = 1'b1
   } mon_state_t;
endpackage

// File: rtl/rvm_match.sv
// Decodes one status field against the configured trigger code.
module rvm_match #(
   parameter int          STW  = 2,
   parameter logic [31:0] CODE = 32'd1
) (
   input  logic [STW-1:0] code_i,
   output logic           hit_o
);
   localparam logic [STW-1:0] CODE_W = CODE[STW-1:0];

   always_comb hit_o = (code_i == CODE_W);
endmodule

// File: rtl/rvm_window.sv
// Tick counter for one response window.
module rvm_window #(
   parameter int WIN_TICKS = 500
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic advance_i,
   output logic last_o
);
   localparam int CW = (WIN_TICKS < 2) ? 1 : $clog2(WIN_TICKS);
   localparam logic [CW-1:0] LAST_CNT = CW'(WIN_TICKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)            cnt_q <= '0;
      else if (start_i)   cnt_q <= '0;
      else if (advance_i) cnt_q <= cnt_q + 1'b1;
   end

   always_comb last_o = (cnt_q == LAST_CNT);
endmodule

// File: rtl/rvm_monitor.sv
// One timed requirement: trigger decode, window, sticky flags.
module rvm_monitor
   import rvm_pkg::*;
#(
   parameter int          STW       = 2,
   parameter logic [31:0] TRIG_CODE = 32'd1,
   parameter int          WIN_TICKS = 500
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           tick,
   input  logic [STW-1:0] code_i,
   input  logic           resp_i,
   output logic           eval_o,
   output logic           viol_o,
   output logic           busy_o
);
   mon_state_t st_q;
   logic       trig;
   logic       last;
   logic       start;
   logic       met;
   logic       expire;
   logic       advance;

   rvm_match #(.STW(STW), .CODE(TRIG_CODE)) u_match (
      .code_i (code_i),
      .hit_o  (trig)
   );

   always_comb begin
      start   = (st_q == MS_IDLE) && trig && !resp_i;
      met     = ((st_q == MS_IDLE) && trig && resp_i) ||
                ((st_q == MS_ARMED) && resp_i);
      advance = (st_q == MS_ARMED) && !resp_i && tick;
      expire  = advance && last;
   end

   rvm_window #(.WIN_TICKS(WIN_TICKS)) u_win (
      .clk       (clk),
      .rst       (rst),
      .start_i   (start),
      .advance_i (advance),
      .last_o    (last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= MS_IDLE;
         eval_o <= 1'b0;
         viol_o <= 1'b0;
      end else begin
         if (start)             st_q <= MS_ARMED;
         else if (met || expire) st_q <= MS_IDLE;
         if (met || expire) eval_o <= 1'b1;
         if (expire)        viol_o <= 1'b1;
      end
   end

   always_comb busy_o = (st_q == MS_ARMED);
endmodule

// File: rtl/rvm_verdict.sv
// Combines N monitor flags into pass / fail.
module rvm_verdict #(
   parameter int N   = 4,
   parameter bit REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] eval_i,
   input  logic [N-1:0] viol_i,
   output logic         pass_o,
   output logic         fail_o
);
   logic pass_c;
   logic fail_c;

   always_comb begin
      fail_c = |viol_i;
      pass_c = (&eval_i) && !fail_c;
   end

   if (REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            pass_o <= 1'b0;
            fail_o <= 1'b0;
         end else begin
            pass_o <= pass_c;
            fail_o <= fail_c;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      always_comb begin
         unused_clk = clk ^ rst;
         pass_o     = pass_c;
         fail_o     = fail_c;
      end
   end
endmodule

// File: rtl/rvm_array.sv
// Array of timed requirement monitors with a joint verdict.
module rvm_array #(
   parameter int          N_MON        = 4,
   parameter int          STW          = 2,
   parameter logic [31:0] CAUTION_CODE = 32'd1,
   parameter int          WIN_TICKS    = 500,
   parameter bit          REG_VERDICT  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 tick,
   input  logic [N_MON*STW-1:0] status,
   input  logic [N_MON-1:0]     resp,
   output logic [N_MON-1:0]     evaluated,
   output logic [N_MON-1:0]     violated,
   output logic                 test_pass,
   output logic                 test_fail
);
   if (N_MON < 1)                     begin : g_bad_n   $error("N_MON must be at least 1"); end
   if (STW < 1)                       begin : g_bad_w   $error("STW must be at least 1"); end
   if (WIN_TICKS < 1)                 begin : g_bad_win $error("WIN_TICKS must be at least 1"); end
   if (CAUTION_CODE >= (64'd1 << STW)) begin : g_bad_c  $error("CAUTION_CODE does not fit STW"); end

   logic [N_MON-1:0] mon_busy;

   for (genvar i = 0; i < N_MON; i++) begin : g_mon
      rvm_monitor #(
         .STW       (STW),
         .TRIG_CODE (CAUTION_CODE),
         .WIN_TICKS (WIN_TICKS)
      ) u_mon (
         .clk    (clk),
         .rst    (rst),
         .tick   (tick),
         .code_i (status[i*STW +: STW]),
         .resp_i (resp[i]),
         .eval_o (evaluated[i]),
         .viol_o (violated[i]),
         .busy_o (mon_busy[i])
      );
   end

   rvm_verdict #(.N(N_MON), .REG(REG_VERDICT)) u_verdict (
      .clk    (clk),
      .rst    (rst),
      .eval_i (evaluated),
      .viol_i (violated),
      .pass_o (test_pass),
      .fail_o (test_fail)
   );
endmodule

// File: rtl/rvm_array_chk.sv
module rvm_array_chk #(
   parameter int          N_MON        = 4,
   parameter int          STW          = 2,
   parameter logic [31:0] CAUTION_CODE = 32'd1,
   parameter bit          REG_VERDICT  = 1'b0
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 tick,
   input logic [N_MON*STW-1:0] status,
   input logic [N_MON-1:0]     resp,
   input logic [N_MON-1:0]     evaluated,
   input logic [N_MON-1:0]     violated,
   input logic [N_MON-1:0]     mon_busy,
   input logic                 test_pass,
   input logic                 test_fail
);
   localparam logic [STW-1:0] CW_CODE = CAUTION_CODE[STW-1:0];

   for (genvar i = 0; i < N_MON; i++) begin : g_p
      p_eval_sticky_r5: assert property (@(posedge clk) disable iff (rst)
         evaluated[i] |=> evaluated[i]);
      p_viol_sticky_r5: assert property (@(posedge clk) disable iff (rst)
         violated[i] |=> violated[i]);
      p_viol_has_eval_r3: assert property (@(posedge clk) disable iff (rst)
         violated[i] |-> evaluated[i]);
      p_viol_cause_r3: assert property (@(posedge clk) disable iff (rst)
         $rose(violated[i]) |-> ($past(mon_busy[i]) && $past(tick) && !$past(resp[i])));
      p_eval_cause_r2: assert property (@(posedge clk) disable iff (rst)
         ($rose(evaluated[i]) && !violated[i]) |-> $past(resp[i]));
      p_arm_cause_r1: assert property (@(posedge clk) disable iff (rst)
         $rose(mon_busy[i]) |-> ($past(status[i*STW +: STW]) == CW_CODE));
   end

   p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (evaluated == '0 && violated == '0 && mon_busy == '0));

   if (REG_VERDICT) begin : g_vreg
      p_fail_r8: assert property (@(posedge clk) disable iff (rst)
         (|violated) |=> test_fail);
      p_pass_r7: assert property (@(posedge clk) disable iff (rst)
         test_pass |-> $past(&evaluated) && !$past(|violated));
   end else begin : g_vcomb
      p_fail_r8: assert property (@(posedge clk) disable iff (rst)
         (|violated) |-> test_fail);
      p_pass_r7: assert property (@(posedge clk) disable iff (rst)
         test_pass |-> ((&evaluated) && !(|violated)));
   end
endmodule

bind rvm_array rvm_array_chk #(
   .N_MON        (N_MON),
   .STW          (STW),
   .CAUTION_CODE (CAUTION_CODE),
   .REG_VERDICT  (REG_VERDICT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tick      (tick),
   .status    (status),
   .resp      (resp),
   .evaluated (evaluated),
   .violated  (violated),
   .mon_busy  (mon_busy),
   .test_pass (test_pass),
   .test_fail (test_fail)
);

// File: tb/rvm_array_tb.sv
`timescale 1ns/1ps
module rvm_array_tb;
   localparam int N   = 4;
   localparam int SW  = 2;
   localparam int WIN = 20;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           tick = 1'b0;
   logic [N*SW-1:0] status = '0;
   logic [N-1:0]   resp = '0;
   logic [N-1:0]   evaluated, violated;
   logic           test_pass, test_fail;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [N-1:0] m_eval = '0, m_viol = '0, m_pend = '0;
   int           m_cnt [N];

   always #2.5 clk = ~clk;

   rvm_array #(.N_MON(N), .STW(SW), .CAUTION_CODE(32'd1), .WIN_TICKS(WIN)) u_dut (
      .clk(clk), .rst(rst), .tick(tick), .status(status), .resp(resp),
      .evaluated(evaluated), .violated(violated),
      .test_pass(test_pass), .test_fail(test_fail)
   );

   function automatic logic [N*SW-1:0] code_at(int i, logic [SW-1:0] c);
      logic [N*SW-1:0] v = '0;
      v[i*SW +: SW] = c;
      return v;
   endfunction

   function automatic logic exp_pass();
      return (&m_eval) && !(|m_viol);
   endfunction

   // Requirement model, predicting the state after the next rising edge.
   task automatic model_step();
      for (int i = 0; i < N; i++) begin
         if (rst) begin
            m_eval[i] = 1'b0; m_viol[i] = 1'b0; m_pend[i] = 1'b0; m_cnt[i] = 0;
         end else if (!m_pend[i]) begin
            if (status[i*SW +: SW] == 2'd1) begin
               if (resp[i]) m_eval[i] = 1'b1;
               else begin m_pend[i] = 1'b1; m_cnt[i] = 0; end
            end
         end else if (resp[i]) begin
            m_eval[i] = 1'b1; m_pend[i] = 1'b0;
         end else if (tick) begin
            if (m_cnt[i] + 1 == WIN) begin
               m_viol[i] = 1'b1; m_eval[i] = 1'b1; m_pend[i] = 1'b0;
            end else m_cnt[i] = m_cnt[i] + 1;
         end
      end
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(input string tag);
      chk(evaluated === m_eval, tag, "evaluated", 32'(evaluated), 32'(m_eval));
      chk(violated === m_viol, tag, "violated", 32'(violated), 32'(m_viol));
      chk(test_pass === exp_pass(), tag, "test_pass", 32'(test_pass), 32'(exp_pass()));
      chk(test_fail === (|m_viol), tag, "test_fail", 32'(test_fail), 32'(|m_viol));
   endtask

   // Called at a falling edge: drive, predict, wait one cycle, compare.
   task automatic step(input logic t, input logic [N*SW-1:0] st, input logic [N-1:0] rs,
                       input string tag);
      tick = t; status = st; resp = rs;
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1;
      step(1'b0, '0, '0, tag);
      rst = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
      void'($urandom(32'd4242));
      @(negedge clk);
      do_reset("R9 reset state");

      // R1: non-caution codes do nothing
      step(1'b1, code_at(0, 2'd0), '0, "R1 code0");
      step(1'b1, code_at(0, 2'd2), '0, "R1 code2");
      step(1'b1, code_at(0, 2'd3), 4'b0001, "R1 code3 with resp");
      chk(evaluated[0] === 1'b0, "R1", "eval0 after non-caution", 32'(evaluated[0]), 0);
      // R2: trigger with response on the same edge
      step(1'b1, code_at(0, 2'd1), 4'b0001, "R2 same-edge resp");
      chk(evaluated[0] === 1'b1 && violated[0] === 1'b0, "R2", "mon0 flags",
          32'({evaluated[0], violated[0]}), 32'b10);

      // R3: response on the WIN-th tick is in time
      step(1'b1, code_at(1, 2'd1), '0, "R3 arm mon1");
      for (int k = 1; k < WIN; k++) step(1'b1, '0, '0, "R3 counting");
      chk(evaluated[1] === 1'b0, "R3", "eval1 before last tick", 32'(evaluated[1]), 0);
      step(1'b1, '0, 4'b0010, "R3 resp on last tick");
      chk(evaluated[1] === 1'b1 && violated[1] === 1'b0, "R3", "mon1 in time",
          32'({evaluated[1], violated[1]}), 32'b10);

      // R4: retrigger does not restart; idle cycles do not count
      step(1'b1, code_at(2, 2'd1), '0, "R4 arm mon2");
      for (int k = 0; k < 10; k++) step(1'b1, '0, '0, "R4 ticks");
      step(1'b0, code_at(2, 2'd1), '0, "R4 retrigger");
      for (int k = 0; k < 10; k++) step(1'b0, '0, '0, "R4 no tick");
      for (int k = 0; k < 9; k++) step(1'b1, '0, '0, "R4 ticks");
      chk(violated[2] === 1'b0, "R4", "viol2 before 20th tick", 32'(violated[2]), 0);
      step(1'b1, '0, '0, "R3 expiry");
      chk(violated[2] === 1'b1 && evaluated[2] === 1'b1, "R3", "mon2 expired",
          32'({evaluated[2], violated[2]}), 32'b11);
      chk(test_fail === 1'b1, "R8", "fail with one violation", 32'(test_fail), 1);

      // R6: mon3 never triggered keeps pass low
      chk(evaluated[3] === 1'b0 && test_pass === 1'b0, "R6", "untriggered mon3",
          32'({evaluated[3], test_pass}), 0);
      step(1'b0, code_at(3, 2'd1), 4'b1000, "R6 mon3 done");
      chk(test_pass === 1'b0, "R7", "pass blocked by violation", 32'(test_pass), 0);
      // R5: sticky against further stimulus
      step(1'b1, code_at(2, 2'd1), 4'b0100, "R5 after violation");
      chk(violated[2] === 1'b1, "R5", "viol2 sticky", 32'(violated[2]), 1);

      // R9: reset in the middle of an open window
      step(1'b1, code_at(0, 2'd1) | code_at(1, 2'd1), '0, "R9 arm before reset");
      do_reset("R9 reset clears");
      step(1'b1, '0, 4'b1111, "R9 stale resp");
      chk(evaluated === '0, "R9", "no stale completion", 32'(evaluated), 0);

      // R7: all evaluated and clean -> pass
      step(1'b0, {2'd1, 2'd1, 2'd1, 2'd1}, 4'b1111, "R7 all met");
      chk(test_pass === 1'b1 && test_fail === 1'b0, "R7", "pass",
          32'({test_pass, test_fail}), 32'b10);
      step(1'b1, {2'd0, 2'd3, 2'd2, 2'd0}, '0, "R5 stays");

      // Random phase
      do_reset("R9 before random");
      for (int n = 0; n < 6000; n++) begin
         logic [N*SW-1:0] st;
         logic [N-1:0]    rs;
         for (int i = 0; i < N; i++) begin
            st[i*SW +: SW] = SW'($urandom_range(0, 3));
            rs[i] = ($urandom_range(0, 39) == 0);
         end
         if ($urandom_range(0, 799) == 0) do_reset("R9 random reset");
         else step(logic'($urandom_range(0, 2) == 0), st, rs, "R2 R3 R4 R5 R7 R8 random");
      end

      summary();
      $finish;
   end
endmodule